// File: doc/BRIEF.md
# Self-Configuring TDM Voice Sample Port

This block connects a frame-synchronised serial voice bus to a parallel sample interface. It runs entirely in the system clock domain. The double-rate bit clock, the frame sync and the serial data input are registered, and the block acts on the bit-clock edges it detects. By watching the frame sync, it decides which bus convention is in use. A short low pulse after a long high idle is one convention. A short high pulse after a long low idle is the mirrored one. A sync that never leaves low is the held-low mode. The detected convention then sets which bit-clock edge launches output bits and which edge captures input bits.

Each frame carries one voice sample. It is either an 8-bit companded byte in timeslot 0, or a 16-bit two's-complement word spread over timeslots 0 and 1. The serial output is enabled only while the assigned bits are on the wire. The sample to send is taken from the parallel side at every frame start. The received sample is presented with a one-cycle strobe. A ready flag tells configuration logic when the port has settled after reset.

Top module: `tdm_pcm_port`

## Requirements
- R1: While rstN is low, serOe, rxValid, ready and modeLocked are all 0.
- R2: The convention is reported on busMode: 0 for a low frame pulse after an idle-high run of at least MIN_IDLE_HALF bit-clock edges, 1 for a high pulse after an equally long idle-low run, and 2 for a sync sampled low on every edge of a whole frame. modeLocked rises once two consecutive observations agree.
- R3: A locked convention keeps its value after a single frame of the other polarity. It changes only on the second consecutive frame of the new polarity.
- R4: With busMode 0 or 2, output bits launch on falling bit-clock edges and input bits are captured on rising edges. With busMode 1 the two edges are swapped. Each bit cell is two bit-clock periods long and is captured three quarters of the way in.
- R5: With wideMode 0, timeslot 0 (bits 0 to 7 after the frame start) carries txSample[7:0], most significant bit first.
- R6: With wideMode 1, timeslots 0 and 1 (bits 0 to 15) carry txSample[15:0], most significant bit first, so the high byte goes in slot 0.
- R7: serOe is 1 exactly during the assigned bit cells, and only when modeLocked is 1. Outside them serOe is 0.
- R8: serIn is ignored outside the assigned bit cells. In 8-bit mode rxSample is {8'h00, received byte}, and in 16-bit mode it is the received word, first bit in bit 15.
- R9: rxValid pulses for exactly one cycle, once per frame, after the last assigned bit has been captured.
- R10: txSample and wideMode are taken at the frame start. Changes later in the frame do not affect that frame.
- R11: ready stays 0 until READY_FRAMES+1 frame boundaries have been seen since reset (that is, READY_FRAMES complete frames), then stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than bitClk |
| rstN | input | 1 | Asynchronous active-low reset |
| bitClk | input | 1 | Bit clock at twice the serial data rate |
| frameSync | input | 1 | 8 kHz frame sync in any of the three conventions |
| serIn | input | 1 | Serial receive data |
| serOut | output | 1 | Serial transmit data, 0 when not enabled |
| serOe | output | 1 | Output enable for serOut (0 = high impedance) |
| wideMode | input | 1 | 1 = 16-bit linear over two slots, 0 = 8-bit in slot 0 |
| txSample | input | 16 | Sample to transmit, taken at frame start |
| rxSample | output | 16 | Last received sample |
| rxValid | output | 1 | One-cycle strobe with a new rxSample |
| busMode | output | 2 | Detected convention: 0 low pulse, 1 high pulse, 2 held low |
| modeLocked | output | 1 | A convention has been confirmed |
| ready | output | 1 | Ready-delay after reset has expired |

## Verification
The bench runs both pulse conventions with the bit clock shaped to match each one. A port that used the wrong edges would be off by half a bit cell: its serial output and its captured sample would both be shifted by one bit. Garbage is driven on serIn outside the assigned bits, so a port that captured the wrong slot count or the wrong slot would corrupt rxSample. txSample and wideMode are flipped right after each frame start, so a port that read them live would send the wrong data. Two further cases are covered. A single frame of the opposite polarity must leave busMode unchanged, which a port locking on one observation would fail. The ready flag is probed exactly between the eighth and ninth frame boundaries, which catches a ready counter that is off by one.

// File: rtl/tdm_pcm_pkg.sv
package tdm_pcm_pkg;

  localparam int BIT_IDX_W = 8;

  typedef enum logic [1:0] {
    CONV_LOWPULSE  = 2'd0,
    CONV_HIGHPULSE = 2'd1,
    CONV_HELDLOW   = 2'd2
  } conv_e;

  typedef struct packed {
    logic                 frameTick;
    logic                 launch;
    logic                 capture;
    logic [BIT_IDX_W-1:0] bitIdx;
    logic                 rxBit;
  } strobe_t;

endpackage

// File: rtl/tdm_ctrl.sv
module tdm_ctrl
  import tdm_pcm_pkg::*;
#(
  parameter int SLOTS         = 32,
  parameter int MIN_IDLE_HALF = 8,
  parameter int READY_FRAMES  = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitClk,
  input  logic    frameSync,
  input  logic    serIn,
  output strobe_t strb,
  output conv_e   busMode,
  output logic    modeLocked,
  output logic    ready
);

  localparam int FRAME_BITS = SLOTS * 8;
  localparam int FRAME_HALF = FRAME_BITS * 2;
  localparam int HOLD_EDGES = FRAME_HALF * 2;
  localparam int RUN_W      = $clog2(HOLD_EDGES + 1);
  localparam int HC_W       = $clog2(FRAME_HALF + 1);
  localparam int RDY_W      = $clog2(READY_FRAMES + 2);

  logic bcQ, bcP, fsQ, siQ;
  logic fsLevel;
  logic [RUN_W-1:0] runCnt;
  conv_e lastObs, conv, convEff, obsKind;
  logic lastValid, locked;
  logic [HC_W-1:0] halfCnt, launchIdx;
  logic [RDY_W-1:0] readyCnt;

  logic edgeAny, edgeRise, levelChange, obsValid, lockNow, lockEff;
  logic launchEdge, captureEdge;

  // Input registers; bit clock edges are seen one stage later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bcQ <= 1'b0;
      bcP <= 1'b0;
      fsQ <= 1'b0;
      siQ <= 1'b0;
    end else begin
      bcQ <= bitClk;
      bcP <= bcQ;
      fsQ <= frameSync;
      siQ <= serIn;
    end
  end

  assign edgeAny     = bcQ ^ bcP;
  assign edgeRise    = bcQ & ~bcP;
  assign levelChange = edgeAny && (fsQ != fsLevel);

  // Convention observation: long idle then a level change, or a held-low frame
  always_comb begin
    obsValid = 1'b0;
    obsKind  = CONV_LOWPULSE;
    if (levelChange && (runCnt >= RUN_W'(MIN_IDLE_HALF))) begin
      obsValid = 1'b1;
      obsKind  = fsQ ? CONV_HIGHPULSE : CONV_LOWPULSE;
    end else if (edgeAny && !levelChange && !fsQ &&
                 (runCnt == RUN_W'(HOLD_EDGES - 1))) begin
      obsValid = 1'b1;
      obsKind  = CONV_HELDLOW;
    end
  end

  assign lockNow = obsValid && lastValid && (obsKind == lastObs);
  assign lockEff = locked | lockNow;
  assign convEff = lockNow ? obsKind : conv;

  assign launchEdge  = edgeAny && ((convEff == CONV_HIGHPULSE) ? edgeRise : !edgeRise);
  assign captureEdge = edgeAny && !launchEdge;

  always_comb begin
    if (obsValid || (halfCnt >= HC_W'(FRAME_HALF))) launchIdx = '0;
    else                                             launchIdx = halfCnt;
  end

  always_comb begin
    strb.frameTick = obsValid && lockEff;
    strb.launch    = launchEdge && lockEff && !launchIdx[0];
    strb.capture   = captureEdge && locked && !halfCnt[0] && (halfCnt != '0);
    strb.rxBit     = siQ;
    if (launchEdge) strb.bitIdx = BIT_IDX_W'(launchIdx >> 1);
    else            strb.bitIdx = BIT_IDX_W'((halfCnt >> 1) - HC_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsLevel   <= 1'b0;
      runCnt    <= '0;
      lastObs   <= CONV_LOWPULSE;
      lastValid <= 1'b0;
      conv      <= CONV_LOWPULSE;
      locked    <= 1'b0;
      halfCnt   <= '0;
      readyCnt  <= '0;
    end else if (edgeAny) begin
      fsLevel <= fsQ;
      if (levelChange || obsValid)               runCnt <= '0;
      else if (runCnt < RUN_W'(HOLD_EDGES))      runCnt <= runCnt + RUN_W'(1);
      if (obsValid) begin
        lastObs   <= obsKind;
        lastValid <= 1'b1;
        if (readyCnt < RDY_W'(READY_FRAMES + 1)) readyCnt <= readyCnt + RDY_W'(1);
      end
      if (lockNow) begin
        conv   <= obsKind;
        locked <= 1'b1;
      end
      if (launchEdge)    halfCnt <= launchIdx + HC_W'(1);
      else if (obsValid) halfCnt <= '0;
    end
  end

  assign busMode    = conv;
  assign modeLocked = locked;
  assign ready      = (readyCnt == RDY_W'(READY_FRAMES + 1));

endmodule

// File: rtl/tdm_dpath.sv
module tdm_dpath
  import tdm_pcm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strb,
  input  logic        wideMode,
  input  logic [15:0] txSample,
  output logic        serOut,
  output logic        serOe,
  output logic [15:0] rxSample,
  output logic        rxValid
);

  logic [15:0] txLat, rxShift, rxNext;
  logic        wideLat, inSlot, lastBit;
  logic [3:0]  txPos;

  assign inSlot  = strb.bitIdx < (wideLat ? BIT_IDX_W'(16) : BIT_IDX_W'(8));
  assign lastBit = strb.bitIdx == (wideLat ? BIT_IDX_W'(15) : BIT_IDX_W'(7));
  assign txPos   = wideLat ? (4'd15 - strb.bitIdx[3:0]) : (4'd7 - strb.bitIdx[3:0]);
  assign rxNext  = {rxShift[14:0], strb.rxBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txLat    <= '0;
      wideLat  <= 1'b0;
      serOut   <= 1'b0;
      serOe    <= 1'b0;
      rxShift  <= '0;
      rxSample <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strb.frameTick) begin
        txLat   <= txSample;
        wideLat <= wideMode;
      end
      if (strb.launch) begin
        if (inSlot) begin
          serOe  <= 1'b1;
          serOut <= txLat[txPos];
        end else begin
          serOe  <= 1'b0;
          serOut <= 1'b0;
        end
      end
      if (strb.capture && inSlot) begin
        rxShift <= rxNext;
        if (lastBit) begin
          rxSample <= wideLat ? rxNext : {8'h00, rxNext[7:0]};
          rxValid  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tdm_pcm_port.sv
module tdm_pcm_port
  import tdm_pcm_pkg::*;
#(
  parameter int SLOTS         = 32,
  parameter int MIN_IDLE_HALF = 8,
  parameter int READY_FRAMES  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitClk,
  input  logic        frameSync,
  input  logic        serIn,
  output logic        serOut,
  output logic        serOe,
  input  logic        wideMode,
  input  logic [15:0] txSample,
  output logic [15:0] rxSample,
  output logic        rxValid,
  output logic [1:0]  busMode,
  output logic        modeLocked,
  output logic        ready
);

  strobe_t strb;
  conv_e   convW;

  tdm_ctrl #(
    .SLOTS(SLOTS),
    .MIN_IDLE_HALF(MIN_IDLE_HALF),
    .READY_FRAMES(READY_FRAMES)
  ) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .bitClk(bitClk),
    .frameSync(frameSync),
    .serIn(serIn),
    .strb(strb),
    .busMode(convW),
    .modeLocked(modeLocked),
    .ready(ready)
  );

  tdm_dpath dpath_i (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .wideMode(wideMode),
    .txSample(txSample),
    .serOut(serOut),
    .serOe(serOe),
    .rxSample(rxSample),
    .rxValid(rxValid)
  );

  assign busMode = convW;

endmodule

// File: rtl/tdm_pcm_port_chk.sv
module tdm_pcm_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       serOe,
  input logic       rxValid,
  input logic       ready,
  input logic       modeLocked,
  input logic [1:0] busMode
);

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (!serOe && !rxValid && !ready && !modeLocked)
        else $error("outputs active during reset");
    end
  end

  // R7
  oe_needs_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    serOe |-> modeLocked);

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R9
  strobe_needs_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> modeLocked);

  // R11
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  // R2
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeLocked |=> modeLocked);

  // R2
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeLocked |-> (busMode != 2'd3));

endmodule

bind tdm_pcm_port tdm_pcm_port_chk chk_i (
  .clk(clk),
  .rstN(rstN),
  .serOe(serOe),
  .rxValid(rxValid),
  .ready(ready),
  .modeLocked(modeLocked),
  .busMode(busMode)
);

// File: tb/tdm_pcm_port_tb_top.sv
module tdm_pcm_port_tb_top;

  localparam int SLOTS     = 4;
  localparam int FRAME_PER = SLOTS * 16;
  localparam int NVEC      = 6;

  // {highPulseConv, wide, tx[15:0], rx[15:0]}
  localparam logic [33:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 16'h00A5, 16'h003C},
    {1'b0, 1'b1, 16'hBEEF, 16'h1234},
    {1'b1, 1'b0, 16'h00C3, 16'h0081},
    {1'b1, 1'b1, 16'h8001, 16'hF00F},
    {1'b0, 1'b1, 16'hFFFF, 16'h0000},
    {1'b1, 1'b1, 16'h0000, 16'hFFFF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitClk = 1'b0;
  logic frameSync = 1'b1;
  logic serIn = 1'b0;
  logic wideMode = 1'b0;
  logic [15:0] txSample = '0;
  logic serOut, serOe, rxValid, modeLocked, ready;
  logic [15:0] rxSample;
  logic [1:0] busMode;

  int checks = 0;
  int errors = 0;
  int rvSeen = 0;
  logic [15:0] rvData = '0;

  always #4 clk = ~clk;

  tdm_pcm_port #(.SLOTS(SLOTS), .MIN_IDLE_HALF(8), .READY_FRAMES(8)) dut_i (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameSync(frameSync),
    .serIn(serIn), .serOut(serOut), .serOe(serOe), .wideMode(wideMode),
    .txSample(txSample), .rxSample(rxSample), .rxValid(rxValid),
    .busMode(busMode), .modeLocked(modeLocked), .ready(ready)
  );

  always @(posedge clk) begin
    if (rxValid) begin
      rvSeen <= rvSeen + 1;
      rvData <= rxSample;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset(input int conv);
    rstN = 1'b0;
    bitClk = (conv == 1) ? 1'b1 : 1'b0;
    frameSync = (conv == 0) ? 1'b1 : 1'b0;
    serIn = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // conv: 0 low pulse, 1 high pulse, 2 held low
  task automatic runFrame(input int conv, input bit wide, input logic [15:0] tx,
                          input logic [15:0] rx, input bit doCheck, input string tag);
    int nb = wide ? 16 : 8;
    logic startLvl = (conv == 1) ? 1'b0 : 1'b1;
    int base = rvSeen;
    bit oeBad = 0;
    bit outBad = 0;
    logic [15:0] expRx = wide ? rx : {8'h00, rx[7:0]};
    txSample = tx;
    wideMode = wide;
    for (int p = 0; p < FRAME_PER; p++) begin
      int n = p / 2;
      @(negedge clk);
      bitClk = startLvl;
      frameSync = (conv == 0) ? (p != 0) : (conv == 1) ? (p == 0) : 1'b0;
      repeat (3) @(negedge clk);
      @(negedge clk);
      bitClk = ~startLvl;
      if (p % 2 == 0)
        serIn = (n < nb) ? (wide ? rx[15 - n] : rx[7 - n]) : ~n[0];
      repeat (2) @(negedge clk);
      if (doCheck && (p % 2 == 0)) begin
        bit expOe = (n < nb);
        if (serOe !== expOe) oeBad = 1;
        if (expOe && (serOut !== (wide ? tx[15 - n] : tx[7 - n]))) outBad = 1;
      end
      if (doCheck && p == 0) begin
        txSample = ~tx;
        wideMode = ~wide;
      end
      @(negedge clk);
    end
    if (doCheck) begin
      // R7 enable window, R4 edge timing
      chk(!oeBad, {tag, " R7 serOe window"}, 32'(oeBad), 0);
      // R5 / R6 / R10 serial data order and latched sample
      chk(!outBad, {tag, wide ? " R6 wide tx bits R10" : " R5 byte tx bits R10"}, 32'(outBad), 0);
      // R8 / R4 received sample
      chk(rvData == expRx, {tag, " R8 rxSample R4"}, 32'(rvData), 32'(expRx));
      // R9 one strobe per frame
      chk((rvSeen - base) == 1, {tag, " R9 rxValid count"}, 32'(rvSeen - base), 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    doReset(0);
    chk(serOe == 1'b0 && rxValid == 1'b0, "R1 reset outputs", {serOe, rxValid}, 0);
    chk(ready == 1'b0 && modeLocked == 1'b0, "R1 reset status", {ready, modeLocked}, 0);

    // Vector table: each vector locks in two frames, then one checked frame
    for (int v = 0; v < NVEC; v++) begin
      logic [33:0] vec = VECS[v];
      int conv = vec[33] ? 1 : 0;
      doReset(conv);
      runFrame(conv, vec[32], vec[31:16], vec[15:0], 0, "setup");
      runFrame(conv, vec[32], vec[31:16], vec[15:0], 0, "setup");
      runFrame(conv, vec[32], vec[31:16], vec[15:0], 1, $sformatf("vec%0d", v));
      // R2 detected convention
      chk(modeLocked && busMode == 2'(conv), "R2 busMode after lock", {modeLocked, busMode}, {1'b1, 2'(conv)});
    end

    // R11 ready delay
    doReset(0);
    for (int f = 0; f < 9; f++) runFrame(0, 0, 16'h0, 16'h0, 0, "rdy");
    chk(ready == 1'b0, "R11 ready low after 8 boundaries", 32'(ready), 0);
    runFrame(0, 0, 16'h0, 16'h0, 0, "rdy");
    chk(ready == 1'b1, "R11 ready high after 9 boundaries", 32'(ready), 1);

    // R3 polarity change needs two frames
    doReset(0);
    for (int f = 0; f < 3; f++) runFrame(0, 0, 16'h0, 16'h0, 0, "convA");
    chk(busMode == 2'd0 && modeLocked, "R2 low pulse locked", {modeLocked, busMode}, 3'b100);
    runFrame(1, 0, 16'h0, 16'h0, 0, "sw1");
    runFrame(1, 0, 16'h0, 16'h0, 0, "sw2");
    chk(busMode == 2'd0, "R3 single high pulse ignored", 32'(busMode), 0);
    runFrame(1, 0, 16'h0, 16'h0, 0, "sw3");
    chk(busMode == 2'd1, "R3 second high pulse switches", 32'(busMode), 1);
    runFrame(1, 0, 16'h005A, 16'h00E7, 1, "afterSwitch");

    // R1 reset from an active, locked state
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(!serOe && !modeLocked && !ready && !rxValid, "R1 reset clears state",
        {serOe, modeLocked, ready, rxValid}, 0);

    // R2 held-low convention
    doReset(2);
    runFrame(2, 0, 16'h0, 16'h0, 0, "held0");
    chk(modeLocked == 1'b0, "R2 held low one frame not locked", 32'(modeLocked), 0);
    runFrame(2, 0, 16'h0, 16'h0, 0, "held1");
    chk(modeLocked && busMode == 2'd2, "R2 held low locked", {modeLocked, busMode}, 3'b110);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule